// File: doc/BRIEF.md
# Programmable Delayed Event Combiner

This block sits beside a slow-running real-time counter. It takes the three single-cycle compare event pulses that the counter's compare logic raises. For each pulse it produces a delayed copy, counted in cycles of the slow clock. One 4-bit delay code sets the delay for every channel. The code maps to cycle counts in a nonlinear way: the counts double from 1 up to 16, then rise in steps of 16 up to 144.

A 3-bit channel mask chooses which delayed events feed a single combined event output. The combined output is the OR of the selected delayed events. Downstream logic can therefore wait on one line instead of three.

Each channel has its own down-counter. If a new source event arrives before the delay has run out, the count restarts from that new event. A delay code of zero, or either of the two unused codes, bypasses the counters. In that case each delayed output follows its source in the same cycle.

Top module: `event_delay_combiner`

## Requirements
- R1: For delay codes 1 to 13, a source event seen in cycle s yields a one-cycle delayed pulse in cycle s+N. N is 1, 2, 4, 8, 16 for codes 1 to 5, and 32, 48, 64, 80, 96, 112, 128, 144 for codes 6 to 13.
- R2: With delay code 0, each delayed output equals its source input in the same cycle.
- R3: Delay codes 14 and 15 behave exactly as code 0.
- R4: The single delay code applies to all three channels alike, so pulses that arrive together on all channels leave together.
- R5: The combined output is high in a cycle exactly when some channel i with mask bit i set (bit 0 for channel 0, bit 1 for channel 1, bit 2 for channel 2) has its delayed output high.
- R6: With the mask at 0, the combined output stays low.
- R7: A source event on a channel whose delay is still pending restarts that channel's count. Only the last event produces a delayed pulse.
- R8: With a non-zero delay, a delayed pulse is one cycle wide and is not followed by another unless a new source event comes.
- R9: Reset, active low and asynchronous, clears all pending delays, and the registered outputs go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock that counts the delay |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_ev | input | 3 | Compare event pulses, one bit per channel |
| delay_code | input | 4 | Shared delay selection code |
| ch_mask | input | 3 | Channels that feed the combined event |
| dly_ev | output | 3 | Delayed event pulses, one bit per channel |
| comb_ev | output | 1 | OR of the masked delayed events |

## Verification
Some rules can be checked on every cycle. The assertions check that the combined output stays quiet under a zero mask. They check the same-cycle bypass for code 0 and for the unused codes, and the single-cycle latency of code 1. They also check that a delayed pulse is never followed directly by another, and that a fresh source event on a non-trivial delay produces no output in the next cycle. Other behaviour only shows over long spans of cycles: the exact arrival cycle for each of the longer delays, restarting on repeated events, and the loss of pending delays across reset. The bench shows these through a model that remembers when each channel's last event occurred.

// File: rtl/event_delay_combiner.sv
`timescale 1ns/1ps
module event_delay_combiner #(
  parameter int NUM_CH = 3,
  parameter int CODE_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] src_ev,
  input  logic [CODE_W-1:0] delay_code,
  input  logic [NUM_CH-1:0] ch_mask,
  output logic [NUM_CH-1:0] dly_ev,
  output logic              comb_ev
);

  localparam int LAST_CODE = 13;
  localparam int LAST_DOUBLING = 5;

  function automatic logic [CNT_W-1:0] decode(input logic [CODE_W-1:0] c);
    int v;
    int ci;
    ci = int'(c);
    if (ci == 0 || ci > LAST_CODE) v = 0;
    else if (ci <= LAST_DOUBLING)  v = 1 << (ci - 1);
    else                           v = (ci - 4) * 16;
    return v[CNT_W-1:0];
  endfunction

  logic [CNT_W-1:0] span;
  logic             bypass;

  assign span   = decode(delay_code);
  assign bypass = (span == '0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [CNT_W-1:0] cnt;
    logic             fire;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt  <= '0;
        fire <= 1'b0;
      end else if (bypass) begin
        cnt  <= '0;
        fire <= 1'b0;
      end else if (src_ev[i]) begin
        if (span == CNT_W'(1)) begin
          cnt  <= '0;
          fire <= 1'b1;
        end else begin
          cnt  <= span - 1'b1;
          fire <= 1'b0;
        end
      end else if (cnt != '0) begin
        cnt  <= cnt - 1'b1;
        fire <= (cnt == CNT_W'(1));
      end else begin
        fire <= 1'b0;
      end
    end

    assign dly_ev[i] = bypass ? src_ev[i] : fire;
  end

  assign comb_ev = |(dly_ev & ch_mask);

endmodule

// File: rtl/event_delay_combiner_chk.sv
`timescale 1ns/1ps
module event_delay_combiner_chk #(
  parameter int NUM_CH = 3,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] src_ev,
  input logic [CODE_W-1:0] delay_code,
  input logic [NUM_CH-1:0] ch_mask,
  input logic [NUM_CH-1:0] dly_ev,
  input logic              comb_ev
);
  logic timed;
  assign timed = (delay_code != '0) && (delay_code < CODE_W'(14));

  assert_mask_zero_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_mask == '0) |-> !comb_ev);

  assert_code_zero_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (delay_code == '0) |-> (dly_ev == src_ev));

  assert_unused_code_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (delay_code >= CODE_W'(14)) |-> (dly_ev == src_ev));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    assert_one_cycle_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (delay_code == CODE_W'(1) && src_ev[i]) |=> (delay_code != CODE_W'(1) || dly_ev[i]));

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (timed && dly_ev[i] && !src_ev[i]) |=> (!timed || !dly_ev[i]));

    assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (timed && delay_code != CODE_W'(1) && src_ev[i]) |=> (!timed || !dly_ev[i]));
  end
endmodule

bind event_delay_combiner event_delay_combiner_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_ev(src_ev), .delay_code(delay_code),
  .ch_mask(ch_mask), .dly_ev(dly_ev), .comb_ev(comb_ev)
);

// File: tb/tb_event_delay_combiner.sv
`timescale 1ns/1ps
module tb_event_delay_combiner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] src_ev = '0;
  logic [3:0] delay_code = 4'd3;
  logic [2:0] ch_mask = 3'b111;
  logic [2:0] dly_ev;
  logic       comb_ev;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  int last [3] = '{-1000, -1000, -1000};

  always #2.5 clk = ~clk;

  event_delay_combiner dut (
    .clk(clk), .rst_n(rst_n), .src_ev(src_ev), .delay_code(delay_code),
    .ch_mask(ch_mask), .dly_ev(dly_ev), .comb_ev(comb_ev)
  );

  function automatic int span_of(input int c);
    if (c == 0 || c > 13) return 0;
    if (c <= 5) return 1 << (c - 1);
    return (c - 4) * 16;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b", tag, what, cyc, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] s, input logic r, input string tag);
    logic [2:0] expv;
    int n;
    string t;
    @(posedge clk);
    #1;
    src_ev = s;
    rst_n  = r;
    @(negedge clk);
    n = span_of(int'(delay_code));
    for (int ch = 0; ch < 3; ch++) begin
      if (n == 0) expv[ch] = s[ch];
      else        expv[ch] = rst_n && (cyc - last[ch] == n);
      t = tag;
      if (t == "") t = (n == 0) ? ((delay_code >= 4'd14) ? "R3" : "R2") : "R1";
      check(dly_ev[ch], expv[ch], t, $sformatf("dly_ev[%0d]", ch));
    end
    t = tag;
    if (t == "") t = (ch_mask == 3'b000) ? "R6" : "R5";
    check(comb_ev, |(expv & ch_mask), t, "comb_ev");
    for (int ch = 0; ch < 3; ch++) begin
      if (!rst_n)     last[ch] = -1000;
      else if (s[ch]) last[ch] = cyc;
    end
    cyc++;
  endtask

  task automatic idle(input int k, input string tag);
    for (int j = 0; j < k; j++) step(3'b000, 1'b1, tag);
  endtask

  initial begin
    #500000;
    miscompares++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int j = 0; j < 3; j++) step(3'b000, 1'b0, "R9");

    delay_code = 4'd0;
    step(3'b101, 1'b1, "R2");
    step(3'b010, 1'b1, "R2");
    delay_code = 4'd14;
    step(3'b010, 1'b1, "R3");
    delay_code = 4'd15;
    step(3'b111, 1'b1, "R3");
    idle(2, "R3");

    delay_code = 4'd7;
    step(3'b111, 1'b1, "R4");
    idle(60, "R4");

    delay_code = 4'd5;
    step(3'b001, 1'b1, "R7");
    idle(9, "R7");
    step(3'b001, 1'b1, "R7");
    idle(30, "R7");

    delay_code = 4'd13;
    step(3'b010, 1'b1, "R9");
    idle(20, "R9");
    step(3'b000, 1'b0, "R9");
    step(3'b000, 1'b0, "R9");
    idle(150, "R9");

    ch_mask = 3'b000;
    delay_code = 4'd2;
    step(3'b111, 1'b1, "R6");
    idle(10, "R6");
    ch_mask = 3'b100;
    step(3'b011, 1'b1, "R5");
    idle(10, "R5");

    ch_mask = 3'b111;
    delay_code = 4'd1;
    step(3'b001, 1'b1, "R8");
    idle(5, "R8");

    for (int c = 1; c <= 13; c++) begin
      delay_code = 4'(c);
      step(3'(1 << (c % 3)), 1'b1, "R1");
      idle(150, "R1");
    end

    for (int seg = 0; seg < 40; seg++) begin
      delay_code = 4'($urandom % 16);
      ch_mask    = 3'($urandom % 8);
      for (int j = 0; j < 300; j++) begin
        logic [2:0] s;
        for (int ch = 0; ch < 3; ch++) s[ch] = ($urandom % 16) == 0;
        step(s, 1'b1, "");
        if (($urandom % 64) == 0) ch_mask = 3'($urandom % 8);
      end
      idle(150, "");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule